// File: doc/BRIEF.md
# Grouped Interrupt Event and Mask Register

This block holds a 32-bit sticky event register and a matching mask register, both reached through a small register port made of an address, a write strobe and 32-bit write data, with read data that follows the address in the same cycle. Single-cycle pulses from the transmit datapath, the frame parser, the data-parity checker and the receive frame filer set event bits. Software acknowledges an event by writing a 1 to its bit.

Each event bit that is also enabled in the mask drives one of three interrupt lines: transmit, receive or error/diagnostic. The block also turns the filer's reported outcome into the right pair of flags. An accepted frame raises the receive-frame event. If the accepting rule carries the general-purpose flag, the general-purpose match event is raised in the same cycle. A table miss raises both the invalid-result flag and the invalid-queue flag. A timeout raises only the invalid-result flag. A frame steered to a disabled ring raises the invalid-queue flag.

Top module: `grp_irq_event_mask`

## Requirements
- R1: After reset the event register, the mask register and all three interrupt outputs are 0.
- R2: Address 1 is the mask register. It is read/write, but only the implemented bits (0 to 5 and 8 to 8+TX_W-1, which is 0x0000FF3F by default) can be stored. Every other bit reads 0.
- R3: Address 0 is the event register. Writing 1 to an event bit clears it. Writing 0 leaves the bit unchanged.
- R4: An event bit contributes to an interrupt only when it is set in both registers. Bits 3 (general-purpose match), 4 (parse error) and 5 (receive frame) drive irq_rx_o. Bits 0 (result invalid), 1 (queue invalid) and 2 (parity error) drive irq_err_o. Bits 8 and up (transmit events) drive irq_tx_o.
- R5: An interrupt output falls in the cycle after its last contributing bit is cleared by a write of 1, or in the cycle after the mask bit of that last contributing bit is written to 0.
- R6: A filer outcome with code 1 (accepted by a general-purpose rule), without a disabled ring, sets bit 3 and bit 5 in the same cycle. Code 0 (accepted) sets only bit 5.
- R7: A filer outcome with code 2 (table exhausted) sets bits 0 and 1 together and does not set bit 5.
- R8: Code 3 (timeout) sets only bit 0. When filer_dis_ring_i is high with any code, bit 1 is set, and neither bit 3 nor bit 5 is set.
- R9: When a hardware set and a software write-1 clear hit the same event bit in the same cycle, the bit ends up set.
- R10: parse_err_i sets bit 4, parity_err_i sets bit 2, and tx_evt_i[k] sets bit 8+k. Once set, these bits stay set until they are cleared.
- R11: Addresses 2 and 3 read 0, and writes to them change neither register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_addr | input | 2 | Register select: 0 selects events, 1 selects the mask |
| reg_we | input | 1 | Write strobe |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for reg_addr, in the same cycle |
| tx_evt_i | input | TX_W | Transmit event pulses |
| parse_err_i | input | 1 | Frame parse error pulse |
| parity_err_i | input | 1 | Stored-data parity error pulse |
| filer_done_i | input | 1 | Filer outcome valid pulse |
| filer_code_i | input | 2 | Outcome: 0 accepted, 1 accepted by a general-purpose rule, 2 table exhausted, 3 timeout |
| filer_dis_ring_i | input | 1 | Frame steered to a disabled ring; qualified by filer_done_i |
| irq_tx_o | output | 1 | Transmit interrupt |
| irq_rx_o | output | 1 | Receive interrupt |
| irq_err_o | output | 1 | Error/diagnostic interrupt |

## Verification
The registers feed both the read port and the interrupt lines directly. A wrong bit in the event or mask state therefore shows up on reg_rdata and on one of the three interrupt lines in the cycle right after the edge that stored it. The bench reads the event register after every stimulus cycle and compares all three lines at the same time. A mis-coupled filer flag, a clear that loses a simultaneous set, or a bit routed to the wrong group is therefore caught within one cycle of the event.

// File: rtl/grp_irq_event_mask.sv
module grp_irq_event_mask #(
  parameter int TX_W = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [1:0]      reg_addr,
  input  logic            reg_we,
  input  logic [31:0]     reg_wdata,
  output logic [31:0]     reg_rdata,
  input  logic [TX_W-1:0] tx_evt_i,
  input  logic            parse_err_i,
  input  logic            parity_err_i,
  input  logic            filer_done_i,
  input  logic [1:0]      filer_code_i,
  input  logic            filer_dis_ring_i,
  output logic            irq_tx_o,
  output logic            irq_rx_o,
  output logic            irq_err_o
);

  localparam int B_RES  = 0;
  localparam int B_QUE  = 1;
  localparam int B_PAR  = 2;
  localparam int B_GP   = 3;
  localparam int B_PERR = 4;
  localparam int B_RXF  = 5;
  localparam int TX_LSB = 8;

  localparam logic [31:0] GRP_ERR = 32'h0000_0007;
  localparam logic [31:0] GRP_RX  = 32'h0000_0038;
  localparam logic [31:0] GRP_TX  = 32'(((64'd1 << TX_W) - 64'd1) << TX_LSB);
  localparam logic [31:0] IMPL    = GRP_ERR | GRP_RX | GRP_TX;

  localparam logic [1:0] C_ACC  = 2'd0;
  localparam logic [1:0] C_GP   = 2'd1;
  localparam logic [1:0] C_EXH  = 2'd2;

  logic [31:0] evt_q, mask_q, set_vec, clr_vec, live;
  logic        evt_wr, mask_wr, accept;

  assign evt_wr  = reg_we && (reg_addr == 2'd0);
  assign mask_wr = reg_we && (reg_addr == 2'd1);
  assign accept  = filer_done_i && !filer_dis_ring_i && !filer_code_i[1];

  always_comb begin
    set_vec         = '0;
    set_vec[B_RXF]  = accept;
    set_vec[B_GP]   = accept && (filer_code_i == C_GP);
    set_vec[B_RES]  = filer_done_i && filer_code_i[1];
    set_vec[B_QUE]  = filer_done_i && ((filer_code_i == C_EXH) || filer_dis_ring_i);
    set_vec[B_PAR]  = parity_err_i;
    set_vec[B_PERR] = parse_err_i;
    set_vec[TX_LSB +: TX_W] = tx_evt_i;
  end

  assign clr_vec = evt_wr ? reg_wdata : 32'd0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      evt_q  <= '0;
      mask_q <= '0;
    end else begin
      evt_q <= ((evt_q & ~clr_vec) | set_vec) & IMPL;
      if (mask_wr) mask_q <= reg_wdata & IMPL;
    end
  end

  always_comb begin
    case (reg_addr)
      2'd0:    reg_rdata = evt_q;
      2'd1:    reg_rdata = mask_q;
      default: reg_rdata = '0;
    endcase
  end

  assign live      = evt_q & mask_q;
  assign irq_tx_o  = |(live & GRP_TX);
  assign irq_rx_o  = |(live & GRP_RX);
  assign irq_err_o = |(live & GRP_ERR);

  AST_MASK_ZERO_SILENCES: assert property (@(posedge clk) disable iff (!rst_n)
    (mask_wr && reg_wdata == 32'd0) |=> (!irq_tx_o && !irq_rx_o && !irq_err_o)); // R5

  AST_W1C_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    evt_wr |=> ((evt_q & $past(reg_wdata & ~set_vec)) == 32'd0)); // R3

  AST_STICKY_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !evt_wr |=> ((evt_q & $past(evt_q)) == $past(evt_q))); // R10

  AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    (|set_vec) |=> ((evt_q & $past(set_vec & IMPL)) == $past(set_vec & IMPL))); // R9

  AST_GP_WITH_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
    (filer_done_i && !filer_dis_ring_i && filer_code_i == C_GP) |=> (evt_q[B_GP] && evt_q[B_RXF])); // R6

  AST_EXHAUST_PAIR: assert property (@(posedge clk) disable iff (!rst_n)
    (filer_done_i && filer_code_i == C_EXH) |=> (evt_q[B_RES] && evt_q[B_QUE])); // R7

  AST_UNUSED_ADDR_READ: assert property (@(posedge clk) disable iff (!rst_n)
    reg_addr[1] |-> (reg_rdata == 32'd0)); // R11

endmodule

// File: tb/grp_irq_event_mask_tb_top.sv
`timescale 1ns/1ps
module grp_irq_event_mask_tb_top;
  localparam int TX_W = 8;
  localparam int NV   = 14;

  logic clk = 0, rst_n = 0;
  logic [1:0]  reg_addr = 0;
  logic        reg_we = 0;
  logic [31:0] reg_wdata = 0, reg_rdata;
  logic [TX_W-1:0] tx_evt_i = 0;
  logic parse_err_i = 0, parity_err_i = 0, filer_done_i = 0, filer_dis_ring_i = 0;
  logic [1:0] filer_code_i = 0;
  logic irq_tx_o, irq_rx_o, irq_err_o;

  int n_chk = 0, n_bad = 0;
  bit done_flag = 0;

  always #2.5 clk = ~clk;

  grp_irq_event_mask #(.TX_W(TX_W)) dut_i (
    .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_we(reg_we),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .tx_evt_i(tx_evt_i),
    .parse_err_i(parse_err_i), .parity_err_i(parity_err_i),
    .filer_done_i(filer_done_i), .filer_code_i(filer_code_i),
    .filer_dis_ring_i(filer_dis_ring_i),
    .irq_tx_o(irq_tx_o), .irq_rx_o(irq_rx_o), .irq_err_o(irq_err_o));

  function automatic logic [67:0] mkv(
    input logic [7:0] tx, input logic perr, input logic par, input logic dn,
    input logic [1:0] code, input logic dis, input logic we, input logic [1:0] a,
    input logic [31:0] wd, input logic [15:0] ev, input logic [2:0] irq);
    return {tx, perr, par, dn, code, dis, we, a, wd, ev, irq};
  endfunction

  // irq field order: {tx, rx, err}
  localparam logic [67:0] VEC [NV] = '{
    mkv(8'h00,0,0,0,2'd0,0,1,2'd1,32'hFFFF_FFFF,16'h0000,3'b000), // enable all
    mkv(8'h01,0,0,0,2'd0,0,0,2'd0,32'h0,        16'h0100,3'b100),
    mkv(8'h00,0,0,1,2'd1,0,0,2'd0,32'h0,        16'h0128,3'b110), // R6
    mkv(8'h00,0,0,1,2'd2,0,0,2'd0,32'h0,        16'h012B,3'b111), // R7
    mkv(8'h00,0,0,0,2'd0,0,1,2'd0,32'h0000_0100,16'h002B,3'b011), // R3
    mkv(8'h00,0,0,0,2'd0,0,1,2'd0,32'h0000_002B,16'h0000,3'b000), // R5
    mkv(8'h00,0,0,1,2'd3,0,0,2'd0,32'h0,        16'h0001,3'b001), // R8
    mkv(8'h00,0,0,1,2'd0,1,0,2'd0,32'h0,        16'h0003,3'b001), // R8
    mkv(8'h00,0,0,0,2'd0,0,1,2'd0,32'h0000_0003,16'h0000,3'b000),
    mkv(8'h00,0,0,1,2'd0,0,0,2'd0,32'h0,        16'h0020,3'b010), // R6
    mkv(8'h00,1,1,0,2'd0,0,0,2'd0,32'h0,        16'h0034,3'b011), // R10
    mkv(8'h00,0,0,0,2'd0,0,1,2'd1,32'h0000_0020,16'h0034,3'b010), // R4
    mkv(8'h00,0,0,0,2'd0,0,1,2'd1,32'h0000_0000,16'h0034,3'b000), // R5
    mkv(8'h00,0,0,0,2'd0,0,1,2'd0,32'hFFFF_FFFF,16'h0000,3'b000)  // R3
  };

  task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string tag);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // drive one cycle at negedge, release at next negedge
  task automatic cyc(input logic [67:0] v);
    @(negedge clk);
    tx_evt_i = v[67:60]; parse_err_i = v[59]; parity_err_i = v[58];
    filer_done_i = v[57]; filer_code_i = v[56:55]; filer_dis_ring_i = v[54];
    reg_we = v[53]; reg_addr = v[52:51]; reg_wdata = v[50:19];
    @(negedge clk);
    tx_evt_i = 0; parse_err_i = 0; parity_err_i = 0; filer_done_i = 0;
    filer_code_i = 0; filer_dis_ring_i = 0; reg_we = 0; reg_addr = 0; reg_wdata = 0;
    #1;
  endtask

  task automatic rd(input logic [1:0] a, output logic [31:0] d);
    reg_addr = a; #1; d = reg_rdata; reg_addr = 0; #1;
  endtask

  task automatic finish_run();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    #(5ns * 5000);
    if (!done_flag) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
    end
  end

  initial begin
    logic [31:0] d;
    repeat (3) @(negedge clk);
    rst_n = 1; #1;
    // R1 reset state
    rd(2'd0, d); chk(d, 32'h0, "R1 event after reset");
    rd(2'd1, d); chk(d, 32'h0, "R1 mask after reset");
    chk({29'd0, irq_tx_o, irq_rx_o, irq_err_o}, 32'h0, "R1 irq after reset");

    for (int i = 0; i < NV; i++) begin
      cyc(VEC[i]);
      rd(2'd0, d);
      chk(d, {16'h0, VEC[i][18:3]}, $sformatf("R4 vec %0d event", i));
      chk({29'd0, irq_tx_o, irq_rx_o, irq_err_o}, {29'd0, VEC[i][2:0]},
          $sformatf("R4 vec %0d irq", i));
    end

    // R2 unimplemented mask bits read 0
    cyc(mkv(8'h00,0,0,0,2'd0,0,1,2'd1,32'hFFFF_FFFF,16'h0,3'b0));
    rd(2'd1, d); chk(d, 32'h0000_FF3F, "R2 mask implemented bits");

    // R11 unused addresses
    cyc(mkv(8'h00,0,0,0,2'd0,0,1,2'd2,32'h0000_0000,16'h0,3'b0));
    rd(2'd1, d); chk(d, 32'h0000_FF3F, "R11 write addr2 ignored");
    rd(2'd2, d); chk(d, 32'h0, "R11 read addr2 zero");
    cyc(mkv(8'h00,0,0,0,2'd0,0,1,2'd3,32'h0000_0000,16'h0,3'b0));
    rd(2'd3, d); chk(d, 32'h0, "R11 read addr3 zero");
    rd(2'd1, d); chk(d, 32'h0000_FF3F, "R11 write addr3 ignored");

    // R9 set wins over simultaneous clear (bit 9), bit 8 cleared
    cyc(mkv(8'h01,0,0,0,2'd0,0,0,2'd0,32'h0,16'h0,3'b0));
    cyc(mkv(8'h02,0,0,0,2'd0,0,1,2'd0,32'h0000_0300,16'h0,3'b0));
    rd(2'd0, d); chk(d, 32'h0000_0200, "R9 set beats clear");
    chk({31'd0, irq_tx_o}, 32'h1, "R9 tx irq kept");

    // R3 write of zeros leaves events
    cyc(mkv(8'h00,0,0,0,2'd0,0,1,2'd0,32'h0000_0000,16'h0,3'b0));
    rd(2'd0, d); chk(d, 32'h0000_0200, "R3 write 0 no effect");
    cyc(mkv(8'h00,0,0,0,2'd0,0,1,2'd0,32'h0000_0200,16'h0,3'b0));
    chk({31'd0, irq_tx_o}, 32'h0, "R5 tx irq drops after clear");

    // R8 general-purpose accept to disabled ring: only queue invalid
    cyc(mkv(8'h00,0,0,1,2'd1,1,0,2'd0,32'h0,16'h0,3'b0));
    rd(2'd0, d); chk(d, 32'h0000_0002, "R8 gp to disabled ring");
    chk({30'd0, irq_rx_o, irq_err_o}, 32'h1, "R8 err irq only");
    // R8 timeout with disabled ring sets both
    cyc(mkv(8'h00,0,0,0,2'd0,0,1,2'd0,32'hFFFF_FFFF,16'h0,3'b0));
    cyc(mkv(8'h00,0,0,1,2'd3,1,0,2'd0,32'h0,16'h0,3'b0));
    rd(2'd0, d); chk(d, 32'h0000_0003, "R8 timeout plus disabled ring");

    // R7 exhaust leaves receive-frame bit clear
    cyc(mkv(8'h00,0,0,0,2'd0,0,1,2'd0,32'hFFFF_FFFF,16'h0,3'b0));
    cyc(mkv(8'h00,0,0,1,2'd2,0,0,2'd0,32'h0,16'h0,3'b0));
    rd(2'd0, d); chk(d, 32'h0000_0003, "R7 exhaust pair, no frame");

    // R10 top transmit bit
    cyc(mkv(8'h80,0,0,0,2'd0,0,0,2'd0,32'h0,16'h0,3'b0));
    rd(2'd0, d); chk(d, 32'h0000_8003, "R10 tx bit 15");
    chk({29'd0, irq_tx_o, irq_rx_o, irq_err_o}, 32'h5, "R4 tx and err groups");

    done_flag = 1;
    finish_run();
  end
endmodule